// File: doc/BRIEF.md
# Programmable-Resolution Watchdog Timer

This block is a memory-mapped watchdog. Software writes a single control word that carries a 20-bit reload value, a 4-bit tick-resolution code, a counting enable and a system-reset enable. A second word, which software can only read, shows the live count. A prescaler divides the reference clock so that one tick lasts 1/2^code of a second. The count falls by one on each tick. Every control write reloads the count, so software keeps the watchdog alive by writing the control word again.

A control write does not reach the counter at once. For a fixed number of cycles after the write, a busy flag is set in both readable words. During that time the count and the prescaler stay still. When the busy flag clears, the count holds the new reload value and the prescaler begins a fresh tick period.

When the count reaches zero while counting is enabled, a sticky timeout output is raised. If reset is enabled, a system-reset pulse is also driven for the rest of that tick. The count then stays at zero until the next control write.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, the control word at offset 0x0 reads 0x004FFFFF (reload 0xFFFFF, code 4, both enables clear, not busy). The count word at offset 0x4 reads 0x000FFFFF. Both outputs are low.
- R2: Control word layout: reload in bits 19:0, resolution code in bits 23:20, reset enable in bit 26, counting enable in bit 27, busy in bit 28. Software cannot write the busy bit. Every other bit reads as zero.
- R3: After a control write, bit 28 of both words reads 1 for LOAD_CYCLES clock cycles and then reads 0. While it reads 1, the live count does not change.
- R4: In the cycle where busy clears, the live count (bits 19:0 of offset 0x4) equals the reload field that was written.
- R5: While enabled, the count falls by one every P clock cycles, where P = max(CLKS_PER_SEC >> code, 1). The first tick after a load comes P cycles after the load.
- R6: The count never wraps. Once it reaches zero it stays at zero until a control write.
- R7: One cycle after the count reaches zero while enabled, the timeout output rises. It stays high until the next control write, which clears it in the write cycle.
- R8: If reset enable is set, the system-reset output rises together with the timeout and falls at the next tick. If reset enable is clear, the system-reset output stays low.
- R9: While counting is disabled, the count stays frozen at its loaded value. No timeout or reset occurs, even when the loaded value is zero.
- R10: A write to offset 0x4 has no effect. The count, the busy flag and the control word are all left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wdt_timeout | output | 1 | Sticky expiry indication |
| sys_rst_out | output | 1 | System-reset pulse on expiry |

## Verification
The bench builds the block with CLKS_PER_SEC set to 64 and LOAD_CYCLES left at 4. With these values, code 0 gives a 64-cycle tick, code 4 a 4-cycle tick, and every code from 6 up is clamped to a 1-cycle tick. This lets the slowest tick, the clamped fastest tick, and a complete expiry with its reset pulse each be checked to the exact cycle in a short run. The busy window is short enough that the freeze of the count and the following load can be observed on every cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    localparam int DATA_W    = 32;
    localparam int CNT_W     = 20;
    localparam int CODE_W    = 4;
    localparam int CODE_LSB  = 20;
    localparam int RSTEN_BIT = 26;
    localparam int EN_BIT    = 27;
    localparam int BUSY_BIT  = 28;
    localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(4);

    typedef struct packed {
        logic              en;
        logic              rst_en;
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  reload;
    } ctrl_t;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int LOAD_CYCLES = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [CNT_W-1:0]    live_cnt,
    output logic [DATA_W-1:0]   bus_rdata,
    output ctrl_t               ctrl,
    output logic                busy,
    output logic                load,
    output logic                wr_ctrl
);
    localparam int BUSY_W = $clog2(LOAD_CYCLES + 1);
    localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] CNT_OFF  = ADDR_W'(4);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [BUSY_W-1:0] busy_cnt;
    } regs_t;

    regs_t regs_d, regs_q;

    assign wr_ctrl = bus_wr && (bus_addr == CTRL_OFF);

    always_comb begin
        regs_d = regs_q;
        if (wr_ctrl) begin
            regs_d.ctrl.reload = bus_wdata[CNT_W-1:0];
            regs_d.ctrl.code   = bus_wdata[CODE_LSB +: CODE_W];
            regs_d.ctrl.rst_en = bus_wdata[RSTEN_BIT];
            regs_d.ctrl.en     = bus_wdata[EN_BIT];
            regs_d.busy_cnt    = BUSY_W'(LOAD_CYCLES);
        end else if (regs_q.busy_cnt != '0) begin
            regs_d.busy_cnt = regs_q.busy_cnt - BUSY_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.ctrl.en     <= 1'b0;
            regs_q.ctrl.rst_en <= 1'b0;
            regs_q.ctrl.code   <= CODE_RST;
            regs_q.ctrl.reload <= '1;
            regs_q.busy_cnt    <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign ctrl = regs_q.ctrl;
    assign busy = (regs_q.busy_cnt != '0);
    assign load = (regs_q.busy_cnt == BUSY_W'(1));

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_OFF) begin
            bus_rdata[CNT_W-1:0]           = regs_q.ctrl.reload;
            bus_rdata[CODE_LSB +: CODE_W]  = regs_q.ctrl.code;
            bus_rdata[RSTEN_BIT]           = regs_q.ctrl.rst_en;
            bus_rdata[EN_BIT]              = regs_q.ctrl.en;
            bus_rdata[BUSY_BIT]            = busy;
        end else if (bus_addr == CNT_OFF) begin
            bus_rdata[CNT_W-1:0]           = live_cnt;
            bus_rdata[BUSY_BIT]            = busy;
        end
    end

    // R3
    busy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> busy);

    // R3
    busy_ends_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !wr_ctrl) |=> !busy);
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
    import wdg_pkg::*;
#(
    parameter int CLKS_PER_SEC = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int PRE_W = $clog2(CLKS_PER_SEC + 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_t;

    pre_t pre_d, pre_q;
    logic [31:0]      per_full;
    logic [PRE_W-1:0] term;

    always_comb begin
        per_full = 32'(CLKS_PER_SEC) >> code;
        term     = (per_full <= 32'd1) ? '0 : PRE_W'(per_full - 32'd1);
        tick     = run && (pre_q.pre == term);
        pre_d    = pre_q;
        if (!run || tick) begin
            pre_d.pre = '0;
        end else begin
            pre_d.pre = pre_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    // R5
    tick_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pre_q.pre == '0));

    // R5
    idle_holds_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_q.pre == '0));
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    input  logic             tick,
    input  logic             en,
    input  logic             rst_en,
    input  logic             busy,
    input  logic             wr_ctrl,
    output logic [CNT_W-1:0] cnt,
    output logic             timeout,
    output logic             sys_rst
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             timeout;
        logic             rst;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic expire;

    always_comb begin
        cnt_d  = cnt_q;
        expire = en && !busy && !wr_ctrl && (cnt_q.cnt == '0) && !cnt_q.timeout;
        if (wr_ctrl) begin
            cnt_d.timeout = 1'b0;
            cnt_d.rst     = 1'b0;
        end
        if (load) begin
            cnt_d.cnt = reload;
        end else if (tick && (cnt_q.cnt != '0)) begin
            cnt_d.cnt = cnt_q.cnt - CNT_W'(1);
        end
        if (expire) begin
            cnt_d.timeout = 1'b1;
            cnt_d.rst     = rst_en;
        end else if (cnt_q.rst && tick) begin
            cnt_d.rst = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q.cnt     <= '1;
            cnt_q.timeout <= 1'b0;
            cnt_q.rst     <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt     = cnt_q.cnt;
    assign timeout = cnt_q.timeout;
    assign sys_rst = cnt_q.rst;

    // R6
    cnt_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt_q.cnt <= $past(cnt_q.cnt)));

    // R9
    frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(cnt_q.cnt));
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
    import wdg_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int CLKS_PER_SEC = 32768,
    parameter int LOAD_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_timeout,
    output logic              sys_rst_out
);
    ctrl_t            ctrl;
    logic             busy;
    logic             load;
    logic             wr_ctrl;
    logic             tick;
    logic [CNT_W-1:0] live_cnt;

    wdg_regs #(
        .ADDR_W      (ADDR_W),
        .LOAD_CYCLES (LOAD_CYCLES)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .live_cnt  (live_cnt),
        .bus_rdata (bus_rdata),
        .ctrl      (ctrl),
        .busy      (busy),
        .load      (load),
        .wr_ctrl   (wr_ctrl)
    );

    wdg_prescaler #(
        .CLKS_PER_SEC (CLKS_PER_SEC)
    ) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl.en && !busy),
        .code  (ctrl.code),
        .tick  (tick)
    );

    wdg_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .reload  (ctrl.reload),
        .tick    (tick),
        .en      (ctrl.en),
        .rst_en  (ctrl.rst_en),
        .busy    (busy),
        .wr_ctrl (wr_ctrl),
        .cnt     (live_cnt),
        .timeout (wdt_timeout),
        .sys_rst (sys_rst_out)
    );

    // R7
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_timeout && !wr_ctrl) |=> wdt_timeout);

    // R8
    rst_needs_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_out |-> (wdt_timeout && ctrl.rst_en));
endmodule

// File: tb/sim_tick_watchdog.sv
`timescale 1ns/1ps
module sim_tick_watchdog;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        wdt_timeout;
    logic        sys_rst_out;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    tick_watchdog #(.ADDR_W(4), .CLKS_PER_SEC(64), .LOAD_CYCLES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_timeout(wdt_timeout), .sys_rst_out(sys_rst_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    function automatic logic [31:0] mk(input logic en, input logic rsten,
                                       input logic [3:0] code, input logic [19:0] rl);
        return {4'b0, en, rsten, 2'b0, code, rl};
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(4'h0, v); chk("R1 ctrl", v, 32'h004F_FFFF);
        rd(4'h4, v); chk("R1 count", v, 32'h000F_FFFF);
        chk("R1 timeout", {31'b0, wdt_timeout}, 32'd0);
        chk("R1 sysrst", {31'b0, sys_rst_out}, 32'd0);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); chk("R2 busy readback", v, 32'h1CFF_FFFF);
        step(4);
        rd(4'h0, v); chk("R2 readback", v, 32'h0CFF_FFFF);
        rd(4'h4, v); chk("R4 full load", v, 32'h000F_FFFF);
    endtask

    task automatic t_busy();
        logic [31:0] v0, v;
        wr(4'h0, mk(1'b1, 1'b0, 4'd4, 20'd100));
        rd(4'h4, v0); chk("R3 busy bit", {31'b0, v0[28]}, 32'd1);
        step(3);
        rd(4'h4, v); chk("R3 frozen while busy", v, v0);
        rd(4'h0, v); chk("R3 still busy", {31'b0, v[28]}, 32'd1);
        step(1);
        rd(4'h4, v); chk("R4 loaded, busy clear", v, 32'd100);
        step(3);
        rd(4'h4, v); chk("R5 code4 before tick", v, 32'd100);
        step(1);
        rd(4'h4, v); chk("R5 code4 first tick", v, 32'd99);
        step(8);
        rd(4'h4, v); chk("R5 code4 two more", v, 32'd97);
    endtask

    task automatic t_slow();
        logic [31:0] v;
        wr(4'h0, mk(1'b1, 1'b0, 4'd0, 20'd2));
        step(4);
        rd(4'h4, v); chk("R4 reload 2", v, 32'd2);
        step(63);
        rd(4'h4, v); chk("R5 code0 before tick", v, 32'd2);
        step(1);
        rd(4'h4, v); chk("R5 code0 tick", v, 32'd1);
    endtask

    task automatic t_fast_norst();
        logic [31:0] v;
        wr(4'h0, mk(1'b1, 1'b0, 4'd15, 20'd3));
        step(4);
        rd(4'h4, v); chk("R4 reload 3", v, 32'd3);
        step(1);
        rd(4'h4, v); chk("R5 clamped tick", v, 32'd2);
        step(2);
        rd(4'h4, v); chk("R6 reached zero", v, 32'd0);
        chk("R7 not yet", {31'b0, wdt_timeout}, 32'd0);
        step(1);
        chk("R7 timeout rises", {31'b0, wdt_timeout}, 32'd1);
        chk("R8 no reset when disabled", {31'b0, sys_rst_out}, 32'd0);
        step(5);
        rd(4'h4, v); chk("R6 holds zero", v, 32'd0);
        chk("R7 sticky", {31'b0, wdt_timeout}, 32'd1);
        chk("R8 still no reset", {31'b0, sys_rst_out}, 32'd0);
    endtask

    task automatic t_reset_pulse();
        logic [31:0] v;
        wr(4'h0, mk(1'b1, 1'b1, 4'd4, 20'd2));
        chk("R7 cleared by write", {31'b0, wdt_timeout}, 32'd0);
        step(4);
        rd(4'h4, v); chk("R4 reload 2 b", v, 32'd2);
        step(8);
        rd(4'h4, v); chk("R5 at zero", v, 32'd0);
        chk("R7 low at zero", {31'b0, wdt_timeout}, 32'd0);
        step(1);
        chk("R7 rise", {31'b0, wdt_timeout}, 32'd1);
        chk("R8 reset rise", {31'b0, sys_rst_out}, 32'd1);
        step(2);
        chk("R8 reset held", {31'b0, sys_rst_out}, 32'd1);
        step(1);
        chk("R8 reset falls at tick", {31'b0, sys_rst_out}, 32'd0);
        chk("R7 stays", {31'b0, wdt_timeout}, 32'd1);
        step(8);
        rd(4'h4, v); chk("R6 no wrap", v, 32'd0);
        chk("R8 no second pulse", {31'b0, sys_rst_out}, 32'd0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        wr(4'h0, mk(1'b0, 1'b1, 4'd4, 20'd0));
        step(24);
        rd(4'h4, v); chk("R9 zero frozen", v, 32'd0);
        chk("R9 no timeout", {31'b0, wdt_timeout}, 32'd0);
        chk("R9 no reset", {31'b0, sys_rst_out}, 32'd0);
        wr(4'h0, mk(1'b0, 1'b0, 4'd2, 20'd5));
        step(34);
        rd(4'h4, v); chk("R9 frozen at 5", v, 32'd5);
    endtask

    task automatic t_count_write();
        logic [31:0] v;
        wr(4'h0, mk(1'b1, 1'b0, 4'd4, 20'd50));
        step(4);
        rd(4'h4, v); chk("R4 reload 50", v, 32'd50);
        wr(4'h4, 32'h0000_0000);
        rd(4'h4, v); chk("R10 count kept, not busy", v, 32'd50);
        rd(4'h0, v); chk("R10 ctrl kept", v, mk(1'b1, 1'b0, 4'd4, 20'd50));
        step(3);
        rd(4'h4, v); chk("R10 counting unaffected", v, 32'd49);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_up();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_fields();
        t_busy();
        t_slow();
        t_fast_norst();
        t_reset_pulse();
        t_disabled();
        t_count_write();
        finish_up();
    end
endmodule